// File: doc/BRIEF.md
# Display Rectangle Window Update Sequencer

This block pushes one rectangular region of pixel bytes into a display controller's frame memory. A single start request carries the inclusive column span, the inclusive row span, the byte address of the first pixel of the top row, and the row stride in bytes. The block then emits a byte stream to a downstream serializer, one byte per accepted handshake. Each byte has a flag that marks it as command or data, and a second flag that marks the end of a burst.

The stream always follows one fixed order. The row window command comes first, with its two row bytes. The column window command follows, with its two column bytes. A write-to-memory command closes the setup burst. After that, each row goes out as its own burst of pixel bytes. Pixel bytes are fetched from a zero-latency byte source addressed by the block. The address advances one byte at a time inside a row and moves by the stride from one row to the next.

A fault reported by the serializer ends the update at once. A request with an inverted span, or with too many bytes per row, is refused before any byte is sent.

Top module: `rect_update_seq`

## Requirements
- R1: The first byte of an update is command 0x75 (out_cmd=1). It is followed by two data bytes (out_cmd=0): the start row, then the end row.
- R2: Next comes command 0x15, followed by two data bytes: the start column, then the end column.
- R3: Command 0x5C comes next. It is the seventh and final byte of the setup burst, and out_last=1 on it and on no earlier setup byte.
- R4: Each row burst holds (col_hi + 1 - col_lo) * 2 data bytes, with out_last=1 only on its final byte.
- R5: Rows go out in ascending order from row_lo to row_hi. Byte k of the n-th row is read from src_base + n*src_stride + k, modulo the address width.
- R6: While out_valid=1 and out_ready=0, the byte, its flags and src_addr hold steady.
- R7: If out_err=1 while a byte is offered, nothing is accepted and the update is abandoned. err pulses high for one cycle on the next cycle, and out_valid is low from then on.
- R8: A start with col_lo > col_hi or row_lo > row_hi is refused. err pulses one cycle later and no byte is offered.
- R9: A start whose per-row byte count exceeds 128 is refused the same way. A count of exactly 128 is accepted.
- R10: done pulses for one cycle on the cycle after the final byte of the last row is accepted, and never together with err.
- R11: A start asserted while an update is in progress is ignored.
- R12: After reset, out_valid, done and err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request an update; sampled only when idle |
| col_lo | input | 8 | First column of the window |
| col_hi | input | 8 | Last column of the window (inclusive) |
| row_lo | input | 8 | First row of the window |
| row_hi | input | 8 | Last row of the window (inclusive) |
| src_base | input | 16 | Source byte address of the first pixel of row_lo |
| src_stride | input | 16 | Source address step between rows |
| src_addr | output | 16 | Address of the pixel byte being offered |
| src_data | input | 8 | Pixel byte at src_addr, same cycle |
| out_valid | output | 1 | A byte is offered downstream |
| out_ready | input | 1 | Serializer accepts the offered byte at this edge |
| out_data | output | 8 | Offered byte |
| out_cmd | output | 1 | 1 = command byte, 0 = data byte |
| out_last | output | 1 | Offered byte ends its burst |
| out_err | input | 1 | Serializer fault; aborts the update |
| done | output | 1 | One-cycle pulse: update completed |
| err | output | 1 | One-cycle pulse: request refused or update aborted |

## Verification
The first setup byte appears on the cycle after the edge that samples start. Each later byte appears on the cycle after the edge that accepted the one before it. done and err show one cycle after their cause, and the abort takes effect on the cycle after out_err is seen. The bench keeps a behavioural queue of expected bytes and expected pulses. It drives inputs and compares outputs only at the falling edge, so each comparison sees the state left by the preceding rising edge. The queue is popped at exactly the handshake the bench itself has just driven. Ready patterns that stall on every third cycle check that an expected byte stays in place until it is accepted.

// File: rtl/rus_pkg.sv
// Shared constants and state type of the rectangle update sequencer.
package rus_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ROWS} rus_state_e;
    localparam logic [7:0] CMD_ROW_WIN = 8'h75;
    localparam logic [7:0] CMD_COL_WIN = 8'h15;
    localparam logic [7:0] CMD_WR_MEM  = 8'h5C;
    localparam int SETUP_BYTES = 7;
    localparam int SETUP_IDX_W = $clog2(SETUP_BYTES);
endpackage

// File: rtl/rus_window_check.sv
// Validates a requested window and derives the per-row byte count.
// Assumes two bytes per column and inclusive spans.
module rus_window_check #(
    parameter int COORD_W       = 8,
    parameter int MAX_ROW_BYTES = 128,
    localparam int LEN_W        = COORD_W + 2
) (
    input  logic [COORD_W-1:0] col_lo,
    input  logic [COORD_W-1:0] col_hi,
    input  logic [COORD_W-1:0] row_lo,
    input  logic [COORD_W-1:0] row_hi,
    output logic               win_ok,
    output logic [LEN_W-1:0]   row_bytes
);
    logic [LEN_W-1:0] span;

    // Span, byte count and acceptance test.
    always_comb begin
        span      = {2'b00, col_hi} - {2'b00, col_lo} + LEN_W'(1);
        row_bytes = span << 1;
        win_ok    = (col_lo <= col_hi) && (row_lo <= row_hi)
                    && (row_bytes <= LEN_W'(MAX_ROW_BYTES));
    end
endmodule

// File: rtl/rus_setup_rom.sv
// Produces the seven setup bytes in their fixed order from a byte index.
// Assumes the index stays below the setup length.
module rus_setup_rom
    import rus_pkg::*;
#(
    parameter int COORD_W = 8
) (
    input  logic [SETUP_IDX_W-1:0] idx,
    input  logic [COORD_W-1:0]     col_lo,
    input  logic [COORD_W-1:0]     col_hi,
    input  logic [COORD_W-1:0]     row_lo,
    input  logic [COORD_W-1:0]     row_hi,
    output logic [7:0]             byte_o,
    output logic                   is_cmd,
    output logic                   is_last
);
    // Byte and flags for the current setup position.
    always_comb begin
        is_cmd  = 1'b0;
        is_last = 1'b0;
        case (idx)
            3'd0:    begin byte_o = CMD_ROW_WIN; is_cmd = 1'b1; end
            3'd1:    byte_o = 8'(row_lo);
            3'd2:    byte_o = 8'(row_hi);
            3'd3:    begin byte_o = CMD_COL_WIN; is_cmd = 1'b1; end
            3'd4:    byte_o = 8'(col_lo);
            3'd5:    byte_o = 8'(col_hi);
            default: begin byte_o = CMD_WR_MEM; is_cmd = 1'b1; is_last = 1'b1; end
        endcase
    end
endmodule

// File: rtl/rect_update_seq.sv
// Sequences a rectangular frame-memory update: setup burst, then one burst
// per row of pixel bytes read from a zero-latency byte source.
// Assumes out_err outranks out_ready in the same cycle.
module rect_update_seq
    import rus_pkg::*;
#(
    parameter int COORD_W       = 8,
    parameter int ADDR_W        = 16,
    parameter int MAX_ROW_BYTES = 128,
    localparam int LEN_W        = COORD_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [COORD_W-1:0] col_lo,
    input  logic [COORD_W-1:0] col_hi,
    input  logic [COORD_W-1:0] row_lo,
    input  logic [COORD_W-1:0] row_hi,
    input  logic [ADDR_W-1:0]  src_base,
    input  logic [ADDR_W-1:0]  src_stride,
    output logic [ADDR_W-1:0]  src_addr,
    input  logic [7:0]         src_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [7:0]         out_data,
    output logic               out_cmd,
    output logic               out_last,
    input  logic               out_err,
    output logic               done,
    output logic               err
);
    rus_state_e             state;
    logic [SETUP_IDX_W-1:0] setup_idx;
    logic [LEN_W-1:0]       byte_cnt, row_bytes_q, row_bytes_w;
    logic [COORD_W-1:0]     col_lo_q, col_hi_q, row_lo_q, row_hi_q, row_cur;
    logic [ADDR_W-1:0]      row_ptr, stride_q;
    logic                   win_ok, done_q, err_q;
    logic [7:0]             setup_byte;
    logic                   setup_cmd, setup_last, row_last, accept;

    rus_window_check #(.COORD_W(COORD_W), .MAX_ROW_BYTES(MAX_ROW_BYTES)) u_check (
        .col_lo(col_lo), .col_hi(col_hi), .row_lo(row_lo), .row_hi(row_hi),
        .win_ok(win_ok), .row_bytes(row_bytes_w)
    );

    rus_setup_rom #(.COORD_W(COORD_W)) u_setup (
        .idx(setup_idx), .col_lo(col_lo_q), .col_hi(col_hi_q),
        .row_lo(row_lo_q), .row_hi(row_hi_q),
        .byte_o(setup_byte), .is_cmd(setup_cmd), .is_last(setup_last)
    );

    // Output mux: setup bytes or pixel bytes, with burst-end flag.
    always_comb begin
        row_last  = (byte_cnt == row_bytes_q - LEN_W'(1));
        out_valid = (state != ST_IDLE);
        src_addr  = row_ptr + ADDR_W'(byte_cnt);
        if (state == ST_SETUP) begin
            out_data = setup_byte;
            out_cmd  = setup_cmd;
            out_last = setup_last;
        end else begin
            out_data = src_data;
            out_cmd  = 1'b0;
            out_last = (state == ST_ROWS) && row_last;
        end
        accept = out_valid && out_ready && !out_err;
    end

    // Sequencer state, counters and status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; setup_idx <= '0; byte_cnt <= '0;
            row_bytes_q <= '0; col_lo_q <= '0; col_hi_q <= '0;
            row_lo_q <= '0; row_hi_q <= '0; row_cur <= '0;
            row_ptr <= '0; stride_q <= '0; done_q <= 1'b0; err_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (state == ST_IDLE) begin
                if (start) begin
                    if (win_ok) begin
                        state <= ST_SETUP; setup_idx <= '0; byte_cnt <= '0;
                        row_bytes_q <= row_bytes_w;
                        col_lo_q <= col_lo; col_hi_q <= col_hi;
                        row_lo_q <= row_lo; row_hi_q <= row_hi;
                        row_cur <= row_lo; row_ptr <= src_base; stride_q <= src_stride;
                    end else begin
                        err_q <= 1'b1;
                    end
                end
            end else if (out_err) begin
                state <= ST_IDLE;
                err_q <= 1'b1;
            end else if (accept) begin
                if (state == ST_SETUP) begin
                    if (setup_last) state <= ST_ROWS;
                    else setup_idx <= setup_idx + 1'b1;
                end else if (row_last) begin
                    byte_cnt <= '0;
                    if (row_cur == row_hi_q) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        row_cur <= row_cur + 1'b1;
                        row_ptr <= row_ptr + stride_q;
                    end
                end else begin
                    byte_cnt <= byte_cnt + 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign err  = err_q;

    // R1
    first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_cmd && out_data == CMD_ROW_WIN));
    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !out_err) |=>
        (out_valid && $stable(out_cmd) && $stable(out_last) && $stable(src_addr)));
    // R7
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |=> (!out_valid && err));
    // R10
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid && out_ready && !out_err && out_last && !out_cmd));
    // R10
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
endmodule

// File: tb/rect_update_seq_tb_top.sv
module rect_update_seq_tb_top;
    logic clk = 1'b0;
    logic rst_n;
    logic start, out_ready, out_err;
    logic [7:0] col_lo, col_hi, row_lo, row_hi;
    logic [15:0] src_base, src_stride, src_addr;
    logic [7:0] src_data, out_data;
    logic out_valid, out_cmd, out_last, done, err;

    always #10 clk = ~clk;

    rect_update_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .col_lo(col_lo), .col_hi(col_hi), .row_lo(row_lo), .row_hi(row_hi),
        .src_base(src_base), .src_stride(src_stride), .src_addr(src_addr),
        .src_data(src_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_cmd(out_cmd), .out_last(out_last),
        .out_err(out_err), .done(done), .err(err)
    );

    function automatic logic [7:0] pix(input logic [15:0] a);
        return a[7:0] + a[15:8] + 8'h3C;
    endfunction
    assign src_data = pix(src_addr);

    typedef struct {
        logic [7:0] d;
        logic       c;
        logic       l;
        logic       fin;
        string      tag;
    } exp_t;

    exp_t q[$];
    int checks = 0, fails = 0, cyc = 0;
    bit exp_done = 0, exp_err = 0, stall_mode = 0;
    string ctx = "R12";

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic c, input logic l,
                        input logic f, input string t);
        exp_t e;
        e.d = d; e.c = c; e.l = l; e.fin = f; e.tag = t;
        q.push_back(e);
    endtask

    // One falling edge: compare, drive next inputs, advance the model.
    task automatic step(input bit st, input bit er);
        bit busy, rdy;
        exp_t e;
        @(negedge clk);
        cyc++;
        chk(out_valid == (q.size() > 0), ctx, "out_valid", out_valid, q.size() > 0);
        if (q.size() > 0 && out_valid) begin
            chk(out_data == q[0].d, q[0].tag, "out_data", out_data, q[0].d);
            chk(out_cmd == q[0].c, q[0].tag, "out_cmd", out_cmd, q[0].c);
            chk(out_last == q[0].l, q[0].c ? "R3" : "R4", "out_last", out_last, q[0].l);
        end
        chk(done == exp_done, "R10", "done", done, exp_done);
        chk(err == exp_err, ctx, "err", err, exp_err);
        exp_done = 0; exp_err = 0;
        rdy = stall_mode ? (cyc % 3 != 0) : 1'b1;
        start = st; out_err = er; out_ready = rdy;
        busy = q.size() > 0;
        if (busy && er) begin
            q.delete();
            exp_err = 1;
        end else if (busy && rdy) begin
            e = q.pop_front();
            if (e.fin) exp_done = 1;
        end
        if (!busy && st) begin
            int cl = col_lo, ch = col_hi, rl = row_lo, rh = row_hi;
            int n = (ch + 1 - cl) * 2;
            if (cl <= ch && rl <= rh && n <= 128) begin
                push(8'h75, 1, 0, 0, "R1"); push(row_lo, 0, 0, 0, "R1");
                push(row_hi, 0, 0, 0, "R1");
                push(8'h15, 1, 0, 0, "R2"); push(col_lo, 0, 0, 0, "R2");
                push(col_hi, 0, 0, 0, "R2");
                push(8'h5C, 1, 1, 0, "R3");
                for (int r = rl; r <= rh; r++)
                    for (int k = 0; k < n; k++)
                        push(pix(16'(src_base + 16'(r - rl) * src_stride + 16'(k))), 0,
                             k == n - 1, (r == rh) && (k == n - 1), "R5");
            end else begin
                exp_err = 1;
            end
        end
    endtask

    task automatic run(input int cl, input int ch, input int rl, input int rh,
                       input int base, input int stride, input string t);
        col_lo = 8'(cl); col_hi = 8'(ch); row_lo = 8'(rl); row_hi = 8'(rh);
        src_base = 16'(base); src_stride = 16'(stride); ctx = t;
        step(1, 0);
        while (q.size() > 0) step(0, 0);
        step(0, 0); step(0, 0);
    endtask

    initial begin
        rst_n = 0; start = 0; out_err = 0; out_ready = 1;
        col_lo = 0; col_hi = 0; row_lo = 0; row_hi = 0; src_base = 0; src_stride = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R12: idle after reset
        step(0, 0); step(0, 0);
        // R1 R2 R3 R4 R5: basic window
        run(0, 1, 2, 3, 100, 16, "R5");
        run(5, 5, 7, 7, 16'hFFFE, 40, "R4");
        // R6: stalled ready pattern
        stall_mode = 1;
        run(3, 6, 0, 2, 16'h1234, 300, "R6");
        stall_mode = 0;
        // R8: inverted spans refused
        run(4, 3, 0, 0, 0, 8, "R8");
        run(0, 0, 9, 8, 0, 8, "R8");
        // R9: 128 bytes accepted, 130 refused
        run(0, 63, 1, 2, 500, 128, "R9");
        run(0, 64, 0, 0, 0, 8, "R9");
        // R7: abort in the middle of a row
        col_lo = 0; col_hi = 3; row_lo = 0; row_hi = 1; src_base = 50; src_stride = 10;
        ctx = "R7";
        step(1, 0);
        repeat (10) step(0, 0);
        step(0, 1);
        repeat (3) step(0, 0);
        // R11: start while busy ignored
        col_lo = 1; col_hi = 2; row_lo = 4; row_hi = 5; src_base = 7; src_stride = 20;
        ctx = "R11";
        step(1, 0);
        step(0, 0);
        col_lo = 9; col_hi = 9; src_base = 900;
        repeat (4) step(1, 0);
        while (q.size() > 0) step(0, 0);
        step(0, 0); step(0, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule